// File: doc/BRIEF.md
# Logarithmic-Domain Multiply, Divide and Square-Root Unit

This block does multiplication, division and square root on numbers held in logarithmic form. A word is one sign bit followed by a two's-complement fixed-point base-2 logarithm of the magnitude. By default the logarithm has 8 integer bits and 23 fraction bits. The three operations become integer work on the logarithm field:

- multiply adds the two logarithms;
- divide subtracts the second logarithm from the first;
- square root shifts the logarithm right by one place, arithmetically.

No mantissa arithmetic is involved. The sign is handled separately.

The unit also covers the cases that integer arithmetic alone does not. It detects the reserved zero and not-a-number codes. It saturates results whose logarithm leaves the field. It flushes results too small to represent to zero. It reports each of these through a flag.

A requester drives two operands, a 2-bit opcode and a valid strobe. With the default parameters the result word and its flags appear one clock later, together with a valid strobe. A parameter gives a purely combinational variant instead.

Top module: `lns_muldiv_sqrt`

## Requirements
- R1: Word layout is `{sign, exp[EXP_W-1:0]}`. The zero code is sign 0 with the exponent field at its most negative value (1 followed by zeros). The NaN code is sign 1 with the same exponent. The largest magnitude has exponent 0 followed by ones. With 8.23 the codes are 32'h4000_0000, 32'hC000_0000 and 32'h3FFF_FFFF.
- R2: Opcode 2'b00 (multiply) returns exponent a+b and sign sa XOR sb.
- R3: Opcode 2'b01 (divide) returns exponent a−b and sign sa XOR sb.
- R4: Opcode 2'b10 (square root) on a positive operand returns the exponent of a shifted right arithmetically by one (floor), with sign 0. Operand b has no effect.
- R5: If a multiply or divide exponent exceeds the largest field value, the result becomes {sign, largest exponent} and the overflow flag is set.
- R6: If a multiply or divide exponent is at or below the most negative field value, the result becomes the zero code and the underflow flag is set.
- R7: A zero operand in a multiply, or a zero dividend with a nonzero divisor, gives the zero code with no flag.
- R8: A zero divisor gives {sign of a, largest exponent} and the invalid flag. This applies even when the dividend is zero.
- R9: Square root of a negative nonzero operand gives the NaN code and the invalid flag. Square root of zero gives zero.
- R10: Any of the following gives the NaN code and the invalid flag: a NaN operand a, a NaN operand b in a multiply or divide, or opcode 2'b11.
- R11: With the output register in place, out_valid_o follows in_valid_i one cycle later. Result and flags load only when in_valid_i is high and otherwise hold. During reset every output is 0.
- R12: At most one of the overflow, underflow and invalid flags is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and opcode are valid |
| op_i | input | 2 | 00 multiply, 01 divide, 10 square root, 11 reserved |
| a_i | input | 32 | First operand (dividend, radicand) |
| b_i | input | 32 | Second operand (divisor) |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 32 | Result word |
| ovf_o | output | 1 | Saturated to largest magnitude |
| udf_o | output | 1 | Flushed to zero |
| inv_o | output | 1 | Invalid operation |

## Verification
The assertions watch the following on every cycle:

- the relation between valid strobes and the hold of the result register;
- that the flags are mutually exclusive;
- that an overflow always carries the largest exponent and an underflow always carries the zero code;
- the fixed outcomes for a negative square root, a zero divisor and the reserved opcode.

Whether an exponent sum, difference or halving is numerically right can only be shown by the bench. It sweeps every operand pair and opcode of a 3.2 configuration against a model built from real exponentials and logarithms. It then runs directed 8.23 cases, which include the saturation and flush boundaries and the floor rounding of odd negative exponents under square root.

// File: rtl/lns_pkg.sv
package lns_pkg;

   typedef enum logic [1:0] {
      LNS_OP_MUL  = 2'b00,
      LNS_OP_DIV  = 2'b01,
      LNS_OP_SQRT = 2'b10,
      LNS_OP_RSVD = 2'b11
   } lns_op_e;

   typedef struct packed {
      logic ovf;
      logic udf;
      logic inv;
   } lns_flags_t;

endpackage

// File: rtl/lns_operand_decode.sv
// Splits a logarithmic word into sign and exponent and recognises the two
// reserved codes that share the most negative exponent.
module lns_operand_decode #(
   parameter int EXP_W = 31
) (
   input  logic [EXP_W:0]   word_i,
   output logic             sign_o,
   output logic [EXP_W-1:0] exp_o,
   output logic             zero_o,
   output logic             nan_o
);
   localparam logic [EXP_W-1:0] CODE_MIN = {1'b1, {(EXP_W-1){1'b0}}};

   logic special;

   assign sign_o  = word_i[EXP_W];
   assign exp_o   = word_i[EXP_W-1:0];
   assign special = (exp_o == CODE_MIN);
   assign zero_o  = special & ~sign_o;
   assign nan_o   = special &  sign_o;
endmodule

// File: rtl/lns_exp_arith.sv
// Exponent datapath: one guard bit above the field, sum/difference or
// arithmetic halving, followed by a range check against the field limits.
module lns_exp_arith
   import lns_pkg::*;
#(
   parameter int EXP_W        = 31,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  lns_op_e          op_i,
   input  logic [EXP_W-1:0] ea_i,
   input  logic [EXP_W-1:0] eb_i,
   output logic [EXP_W-1:0] exp_o,
   output logic             ovf_o,
   output logic             udf_o
);
   localparam int WW = EXP_W + 1;
   localparam logic signed [WW-1:0] LIM_HI = {2'b00, {(EXP_W-1){1'b1}}};
   localparam logic signed [WW-1:0] LIM_LO = {2'b11, {(EXP_W-1){1'b0}}};

   logic signed [WW-1:0] ea_w, eb_w, addsub, halved, wide;
   logic                 is_sub;

   assign ea_w   = {ea_i[EXP_W-1], ea_i};
   assign eb_w   = {eb_i[EXP_W-1], eb_i};
   assign is_sub = (op_i == LNS_OP_DIV);
   assign halved = {ea_i[EXP_W-1], ea_i[EXP_W-1], ea_i[EXP_W-1:1]};

   generate
      if (SHARED_ADDER) begin : g_shared
         logic signed [WW-1:0] b_opnd;
         assign b_opnd = is_sub ? ~eb_w : eb_w;
         assign addsub = ea_w + b_opnd + {{EXP_W{1'b0}}, is_sub};
      end else begin : g_split
         logic signed [WW-1:0] sum_w, dif_w;
         assign sum_w  = ea_w + eb_w;
         assign dif_w  = ea_w - eb_w;
         assign addsub = is_sub ? dif_w : sum_w;
      end
   endgenerate

   assign wide  = (op_i == LNS_OP_SQRT) ? halved : addsub;
   assign ovf_o = (wide >  LIM_HI);
   assign udf_o = (wide <= LIM_LO);
   assign exp_o = wide[EXP_W-1:0];
endmodule

// File: rtl/lns_result_pack.sv
// Applies the special-case priority and forms the result word and flags.
module lns_result_pack
   import lns_pkg::*;
#(
   parameter int EXP_W = 31
) (
   input  lns_op_e          op_i,
   input  logic             sa_i,
   input  logic             sb_i,
   input  logic             za_i,
   input  logic             zb_i,
   input  logic             na_i,
   input  logic             nb_i,
   input  logic [EXP_W-1:0] exp_i,
   input  logic             ovf_i,
   input  logic             udf_i,
   output logic [EXP_W:0]   word_o,
   output lns_flags_t       flags_o
);
   localparam logic [EXP_W-1:0] EXP_MIN  = {1'b1, {(EXP_W-1){1'b0}}};
   localparam logic [EXP_W-1:0] EXP_MAX  = {1'b0, {(EXP_W-1){1'b1}}};
   localparam logic [EXP_W:0]   W_ZERO   = {1'b0, EXP_MIN};
   localparam logic [EXP_W:0]   W_NAN    = {1'b1, EXP_MIN};

   logic sx;
   assign sx = sa_i ^ sb_i;

   always_comb begin
      word_o  = {sx, exp_i};
      flags_o = '0;
      if (op_i == LNS_OP_RSVD || na_i || (op_i != LNS_OP_SQRT && nb_i)) begin
         word_o      = W_NAN;
         flags_o.inv = 1'b1;
      end else if (op_i == LNS_OP_SQRT) begin
         if (za_i) begin
            word_o = W_ZERO;
         end else if (sa_i) begin
            word_o      = W_NAN;
            flags_o.inv = 1'b1;
         end else begin
            word_o = {1'b0, exp_i};
         end
      end else if (op_i == LNS_OP_DIV && zb_i) begin
         word_o      = {sa_i, EXP_MAX};
         flags_o.inv = 1'b1;
      end else if (za_i || zb_i) begin
         word_o = W_ZERO;
      end else if (ovf_i) begin
         word_o      = {sx, EXP_MAX};
         flags_o.ovf = 1'b1;
      end else if (udf_i) begin
         word_o      = W_ZERO;
         flags_o.udf = 1'b1;
      end
   end
endmodule

// File: rtl/lns_muldiv_sqrt.sv
module lns_muldiv_sqrt
   import lns_pkg::*;
#(
   parameter int INT_W        = 8,
   parameter int FRAC_W       = 23,
   parameter bit REG_OUT      = 1'b1,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int EXP_W       = INT_W + FRAC_W,
   localparam int W           = EXP_W + 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         in_valid_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         out_valid_o,
   output logic [W-1:0] result_o,
   output logic         ovf_o,
   output logic         udf_o,
   output logic         inv_o
);
   initial begin : elab_chk
      assert (INT_W >= 2)  else $error("INT_W must be at least 2");
      assert (FRAC_W >= 1) else $error("FRAC_W must be at least 1");
   end

   lns_op_e                  op;
   logic [1:0][W-1:0]        opnd;
   logic [1:0]               sgn, zro, nan;
   logic [1:0][EXP_W-1:0]    ex;
   logic [EXP_W-1:0]         ar_exp;
   logic                     ar_ovf, ar_udf;
   logic [W-1:0]             word;
   lns_flags_t               flags;

   assign op      = lns_op_e'(op_i);
   assign opnd[0] = a_i;
   assign opnd[1] = b_i;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_dec
         lns_operand_decode #(.EXP_W(EXP_W)) u_dec (
            .word_i (opnd[i]),
            .sign_o (sgn[i]),
            .exp_o  (ex[i]),
            .zero_o (zro[i]),
            .nan_o  (nan[i])
         );
      end
   endgenerate

   lns_exp_arith #(.EXP_W(EXP_W), .SHARED_ADDER(SHARED_ADDER)) u_arith (
      .op_i  (op),
      .ea_i  (ex[0]),
      .eb_i  (ex[1]),
      .exp_o (ar_exp),
      .ovf_o (ar_ovf),
      .udf_o (ar_udf)
   );

   lns_result_pack #(.EXP_W(EXP_W)) u_pack (
      .op_i    (op),
      .sa_i    (sgn[0]),
      .sb_i    (sgn[1]),
      .za_i    (zro[0]),
      .zb_i    (zro[1]),
      .na_i    (nan[0]),
      .nb_i    (nan[1]),
      .exp_i   (ar_exp),
      .ovf_i   (ar_ovf),
      .udf_i   (ar_udf),
      .word_o  (word),
      .flags_o (flags)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic         vld_q;
         logic [W-1:0] res_q;
         lns_flags_t   fl_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               vld_q <= 1'b0;
               res_q <= '0;
               fl_q  <= '0;
            end else begin
               vld_q <= in_valid_i;
               if (in_valid_i) begin
                  res_q <= word;
                  fl_q  <= flags;
               end
            end
         end
         assign out_valid_o = vld_q;
         assign result_o    = res_q;
         assign ovf_o       = fl_q.ovf;
         assign udf_o       = fl_q.udf;
         assign inv_o       = fl_q.inv;
      end else begin : g_comb
         assign out_valid_o = in_valid_i;
         assign result_o    = word;
         assign ovf_o       = flags.ovf;
         assign udf_o       = flags.udf;
         assign inv_o       = flags.inv;
      end
   endgenerate
endmodule

// File: rtl/lns_mds_checker.sv
module lns_mds_checker #(
   parameter int EXP_W   = 31,
   parameter bit REG_OUT = 1'b1
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           in_valid_i,
   input logic [1:0]     op_i,
   input logic [EXP_W:0] a_i,
   input logic [EXP_W:0] b_i,
   input logic           out_valid_o,
   input logic [EXP_W:0] result_o,
   input logic           ovf_o,
   input logic           udf_o,
   input logic           inv_o
);
   localparam logic [EXP_W-1:0] E_MIN = {1'b1, {(EXP_W-1){1'b0}}};
   localparam logic [EXP_W-1:0] E_MAX = {1'b0, {(EXP_W-1){1'b1}}};
   localparam logic [EXP_W:0]   ZW    = {1'b0, E_MIN};
   localparam logic [EXP_W:0]   NW    = {1'b1, E_MIN};

   AST_FLAGS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ovf_o, udf_o, inv_o})); // R12
   AST_OVF_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> result_o[EXP_W-1:0] == E_MAX); // R5
   AST_UDF_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      udf_o |-> result_o == ZW); // R6

   generate
      if (REG_OUT) begin : g_seq
         AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            out_valid_o == $past(in_valid_i)); // R11
         AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$past(in_valid_i) |-> $stable(result_o) && $stable({ovf_o, udf_o, inv_o})); // R11
         AST_SQRT_NEGATIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(in_valid_i && op_i == 2'b10 && a_i[EXP_W] && a_i[EXP_W-1:0] != E_MIN)
            |-> result_o == NW && inv_o); // R9
         AST_SQRT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(in_valid_i && op_i == 2'b10) |-> !result_o[EXP_W] || inv_o); // R4
         AST_DIV_BY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(in_valid_i && op_i == 2'b01 && b_i == ZW && a_i[EXP_W-1:0] != E_MIN)
            |-> inv_o && result_o[EXP_W-1:0] == E_MAX); // R8
         AST_RESERVED_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(in_valid_i && op_i == 2'b11) |-> inv_o && result_o == NW); // R10
      end
   endgenerate
endmodule

bind lns_muldiv_sqrt lns_mds_checker #(.EXP_W(EXP_W), .REG_OUT(REG_OUT)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .in_valid_i  (in_valid_i),
   .op_i        (op_i),
   .a_i         (a_i),
   .b_i         (b_i),
   .out_valid_o (out_valid_o),
   .result_o    (result_o),
   .ovf_o       (ovf_o),
   .udf_o       (udf_o),
   .inv_o       (inv_o)
);

// File: tb/lns_muldiv_sqrt_bench.sv
module lns_muldiv_sqrt_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_chk = 0;
   int   n_err = 0;

   always #10 clk = ~clk;

   // small instance: 3.2 format, 6-bit word
   logic       s_vld, s_ovld, s_ovf, s_udf, s_inv;
   logic [1:0] s_op;
   logic [5:0] s_a, s_b, s_res;

   lns_muldiv_sqrt #(.INT_W(3), .FRAC_W(2)) u_lns_small (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(s_vld), .op_i(s_op),
      .a_i(s_a), .b_i(s_b), .out_valid_o(s_ovld), .result_o(s_res),
      .ovf_o(s_ovf), .udf_o(s_udf), .inv_o(s_inv));

   // default instance: 8.23 format, 32-bit word
   logic        b_vld, b_ovld, b_ovf, b_udf, b_inv;
   logic [1:0]  b_op;
   logic [31:0] b_a, b_b, b_res;

   lns_muldiv_sqrt u_lns_muldiv_sqrt (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(b_vld), .op_i(b_op),
      .a_i(b_a), .b_i(b_b), .out_valid_o(b_ovld), .result_o(b_res),
      .ovf_o(b_ovf), .udf_o(b_udf), .inv_o(b_inv));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Real-valued reference: exponent width ew, fraction width fw.
   // Returns the word, flags {ovf,udf,inv} and the requirement tag.
   function automatic void model(input int op, input longint a, input longint b,
                                 input int ew, input int fw,
                                 output longint word, output logic [2:0] flg,
                                 output string tag);
      longint half = longint'(1) <<< (ew - 1);
      longint full = longint'(1) <<< ew;
      longint maxe = half - 1;
      longint zw   = half;
      longint nw   = full | half;
      longint sa   = (a >>> ew) & 1;
      longint sb   = (b >>> ew) & 1;
      longint ea   = a & (full - 1);
      longint eb   = b & (full - 1);
      real    sc   = real'(longint'(1) <<< fw);
      real    ln2  = $ln(2.0);
      real    va, vb, x;
      longint e;
      if (ea >= half) ea -= full;
      if (eb >= half) eb -= full;
      flg  = 3'b000;
      va   = $exp(real'(ea) / sc * ln2);
      vb   = $exp(real'(eb) / sc * ln2);
      if (op == 3 || (ea == -half && sa == 1) || (op != 2 && eb == -half && sb == 1)) begin
         word = nw; flg = 3'b001; tag = "R10";
      end else if (op == 2) begin
         if (ea == -half) begin word = zw; tag = "R9"; end
         else if (sa == 1) begin word = nw; flg = 3'b001; tag = "R9"; end
         else begin
            x = $ln($sqrt(va)) / ln2 * sc;
            word = longint'($floor(x + 0.25)) & (full - 1);
            tag = "R4";
         end
      end else if (op == 1 && eb == -half) begin
         word = (sa << ew) | maxe; flg = 3'b001; tag = "R8";
      end else if (ea == -half || eb == -half) begin
         word = zw; tag = "R7";
      end else begin
         x = (op == 0) ? $ln(va * vb) / ln2 * sc : $ln(va / vb) / ln2 * sc;
         e = longint'($floor(x + 0.5));
         tag = (op == 0) ? "R2" : "R3";
         if (e > maxe) begin word = ((sa ^ sb) << ew) | maxe; flg = 3'b100; tag = "R5"; end
         else if (e <= -half) begin word = zw; flg = 3'b010; tag = "R6"; end
         else word = ((sa ^ sb) << ew) | (e & (full - 1));
      end
   endfunction

   function automatic logic [31:0] enc(input logic s, input real lg);
      longint e = longint'($floor(lg * 8388608.0 + 0.5));
      return {s, e[30:0]};
   endfunction

   task automatic run_big(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
      longint w; logic [2:0] f; string t;
      b_op = op; b_a = a; b_b = b; b_vld = 1'b1;
      @(negedge clk);
      b_vld = 1'b0;
      model(int'(op), longint'(a), longint'(b), 31, 23, w, f, t);
      chk(t, {29'd0, b_ovf, b_udf, b_inv, b_res}, {29'd0, f, w[31:0]});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin : main
      longint w; logic [2:0] f; string t;
      s_vld = 0; s_op = 0; s_a = 0; s_b = 0;
      b_vld = 0; b_op = 0; b_a = 0; b_b = 0;
      repeat (3) @(negedge clk);
      // R11: outputs are zero in reset
      chk("R11", {s_ovld, s_ovf, s_udf, s_inv, s_res}, 64'd0);
      chk("R11", {b_ovld, b_ovf, b_udf, b_inv, b_res}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // exhaustive sweep of the 3.2 configuration
      for (int op = 0; op < 4; op++) begin
         for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
               s_op = op[1:0]; s_a = a[5:0]; s_b = b[5:0]; s_vld = 1'b1;
               @(negedge clk);
               model(op, longint'(a), longint'(b), 5, 2, w, f, t);
               chk(t, {55'd0, s_ovf, s_udf, s_inv, s_res}, {55'd0, f, w[5:0]});
               chk("R12", {63'd0, ($countones({s_ovf, s_udf, s_inv}) <= 1)}, 64'd1);
               chk("R11", {63'd0, s_ovld}, 64'd1);
            end
         end
      end

      // R11: no load without valid; result holds, valid drops
      s_vld = 1'b0; s_op = 2'b00; s_a = 6'h01; s_b = 6'h01;
      w = longint'(s_res);
      @(negedge clk);
      chk("R11", {57'd0, s_ovld, s_res}, {57'd0, 1'b0, w[5:0]});

      // R1: literal code values at 8.23
      run_big(2'b00, 32'h4000_0000, enc(1'b0, 1.25));
      chk("R1", {32'd0, b_res}, {32'd0, 32'h4000_0000});
      run_big(2'b10, 32'hC000_0000, 32'h0);
      chk("R1", {32'd0, b_res}, {32'd0, 32'hC000_0000});
      run_big(2'b00, enc(1'b0, 100.0), enc(1'b0, 100.0));
      chk("R1", {32'd0, b_res}, {32'd0, 32'h3FFF_FFFF});

      // 8.23 directed cases against the real-valued model
      run_big(2'b00, enc(1'b0, 1.5), enc(1'b1, 2.25));           // R2
      run_big(2'b01, enc(1'b1, -3.0), enc(1'b1, 0.75));          // R3
      run_big(2'b10, {1'b0, 31'h7FFF_FFFD}, enc(1'b1, 7.0));     // R4 odd negative
      run_big(2'b10, enc(1'b0, 9.375), 32'h0);                   // R4
      run_big(2'b00, enc(1'b1, 127.0), enc(1'b0, 1.0));          // R5
      run_big(2'b01, enc(1'b0, -100.0), enc(1'b0, 100.0));       // R6
      run_big(2'b01, 32'h4000_0000, enc(1'b0, 3.0));             // R7
      run_big(2'b01, enc(1'b1, 5.0), 32'h4000_0000);             // R8
      run_big(2'b10, enc(1'b1, 2.0), 32'h0);                     // R9
      run_big(2'b11, enc(1'b0, 1.0), enc(1'b0, 1.0));            // R10

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule